// File: doc/BRIEF.md
# PS/2 Set-2 Scancode Sequencer

This block sits between a keyboard matrix scanner and the host-side keyboard interface. Each key event from the scanner carries a 7-bit key position, a flag that tells a press from a release, and a valid strobe. A Ctrl-held status input comes with it. The block converts each event into the byte sequence that PS/2 scancode set 2 defines for that key. It then stores the bytes in a 16-entry circular buffer. The host side drains that buffer one byte per accepted transfer.

The translation runs through two programmable tables. The first maps the key position to an 8-bit intermediate code. Codes below 0x80 are plain one-byte scancodes. Codes at 0x80 or above select an entry of a second, smaller table. That entry names a handler: an extended key with an E0 prefix, the Pause key with its fixed sequences, or no output at all. Both tables can be rewritten through a write port, which changes the keyboard layout.

A sequence is admitted to the buffer whole or not at all. When the buffer has too little free space, the event is dropped and a sticky overflow flag is raised.

Top module: `ps2_set2_seq`

## Requirements
- R1: After reset, out_valid and ovf are both 0.
- R2: The first table maps each of the 128 key positions to an 8-bit intermediate code. It is loaded by a write with tbl_sel=0 at address tbl_addr, using tbl_wdata[7:0].
- R3: An intermediate code below 0x80 yields that code alone on press. On release it yields F0 followed by the code.
- R4: An intermediate code of 0x80 or above uses its low SPEC_AW bits to index the second table, which is loaded by a write with tbl_sel=1. Each entry holds a kind in bits [9:8] and a code in bits [7:0]. Kind 1 is extended and kind 2 is Pause. Kinds 0 and 3 produce no bytes.
- R5: An extended entry yields E0 followed by its code on press. On release it yields E0, then F0, then its code.
- R6: A Pause entry yields E1 14 77 E1 F0 14 F0 77 on press when ctrl_held is 0. It yields E0 7E E0 F0 7E on press when ctrl_held is 1. It yields no bytes on release.
- R7: Bytes leave the buffer in the order they were written, one per cycle in which out_valid and out_ready are both 1. While out_valid is 1 and out_ready is 0, out_byte holds its value.
- R8: A sequence enters the 16-entry buffer only if every one of its bytes fits. Otherwise none of it is stored, and ovf goes to 1 and stays there until reset.
- R9: A table write is ignored in a cycle where key_valid is 1, and in the two cycles after such a cycle.
- R10: With an empty buffer, out_valid stays 0 for the first two clock edges after the edge that samples an event. The first byte of that event is presented after the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_valid | input | 1 | Key event strobe |
| key_pos | input | 7 | Key position |
| key_make | input | 1 | 1 = press, 0 = release |
| ctrl_held | input | 1 | Ctrl key currently held |
| tbl_we | input | 1 | Table write enable |
| tbl_sel | input | 1 | 0 = first table, 1 = second table |
| tbl_addr | input | 7 | Table write address |
| tbl_wdata | input | 10 | Table write data |
| out_valid | output | 1 | Buffer holds a byte |
| out_ready | input | 1 | Host accepts the byte |
| out_byte | output | 8 | Oldest buffered byte |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with its default parameters: 7-bit positions, a second table with 16 entries, and a 16-byte buffer. At that size the bench can load both tables completely. It then drives all 128 positions as both presses and releases, and drives the Pause entries with Ctrl both clear and held, so that every handler and both table lookups are covered. The small buffer lets the bench reach exact fill levels: a completely full buffer, and a partly filled one that rejects an 8-byte Pause but then admits a 3-byte extended release. The bench also tests table writes that collide with an event.

// File: rtl/ps2seq_pkg.sv
package ps2seq_pkg;
  localparam int MAXSEQ = 8;
  localparam int LEN_W  = $clog2(MAXSEQ + 1);

  typedef enum logic [1:0] {
    K_NONE  = 2'd0,
    K_EXT   = 2'd1,
    K_PAUSE = 2'd2,
    K_RSVD  = 2'd3
  } spec_kind_e;

  typedef logic [MAXSEQ-1:0][7:0] seq_t;

  localparam logic [7:0] PFX_EXT   = 8'hE0;
  localparam logic [7:0] PFX_BRK   = 8'hF0;
  localparam logic [7:0] PFX_PAUSE = 8'hE1;
endpackage

// File: rtl/ps2seq_tbl.sv
module ps2seq_tbl #(
  parameter int W  = 8,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ps2seq_build.sv
module ps2seq_build
  import ps2seq_pkg::*;
#(
  parameter int SPEC_W = 10
) (
  input  logic [7:0]        inter,
  input  logic [SPEC_W-1:0] spec,
  input  logic              make,
  input  logic              ctrl,
  output seq_t              seq,
  output logic [LEN_W-1:0]  len
);
  spec_kind_e kind;
  logic [7:0] code;

  assign kind = spec_kind_e'(spec[9:8]);
  assign code = spec[7:0];

  always_comb begin
    seq = '0;
    len = '0;
    if (!inter[7]) begin
      if (make) begin
        seq[0] = inter;
        len    = LEN_W'(1);
      end else begin
        seq[0] = PFX_BRK;
        seq[1] = inter;
        len    = LEN_W'(2);
      end
    end else begin
      case (kind)
        K_EXT: begin
          seq[0] = PFX_EXT;
          if (make) begin
            seq[1] = code;
            len    = LEN_W'(2);
          end else begin
            seq[1] = PFX_BRK;
            seq[2] = code;
            len    = LEN_W'(3);
          end
        end
        K_PAUSE: begin
          if (make && ctrl) begin
            seq[0] = PFX_EXT; seq[1] = 8'h7E; seq[2] = PFX_EXT;
            seq[3] = PFX_BRK; seq[4] = 8'h7E;
            len    = LEN_W'(5);
          end else if (make) begin
            seq[0] = PFX_PAUSE; seq[1] = 8'h14; seq[2] = 8'h77;
            seq[3] = PFX_PAUSE; seq[4] = PFX_BRK; seq[5] = 8'h14;
            seq[6] = PFX_BRK;   seq[7] = 8'h77;
            len    = LEN_W'(8);
          end
        end
        default: len = '0;
      endcase
    end
  end
endmodule

// File: rtl/ps2seq_ring.sv
module ps2seq_ring
  import ps2seq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  seq_t             in_seq,
  input  logic [LEN_W-1:0] in_len,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_byte,
  output logic             ovf
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          room, commit, drop, pop;

  assign room   = (CW'(DEPTH) - count) >= CW'(in_len);
  assign commit = push && (in_len != '0) && room;
  assign drop   = push && (in_len != '0) && !room;
  assign out_valid = (count != '0);
  assign out_byte  = mem[rd_ptr];
  assign pop    = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (commit) begin
      for (int i = 0; i < MAXSEQ; i++) begin
        if (LEN_W'(i) < in_len) mem[wr_ptr + PW'(i)] <= in_seq[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
    end else begin
      if (commit) wr_ptr <= wr_ptr + PW'(in_len);
      if (pop)    rd_ptr <= rd_ptr + PW'(1);
      count <= count + (commit ? CW'(in_len) : '0) - (pop ? CW'(1) : '0);
      if (drop)   ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/ps2_set2_seq.sv
module ps2_set2_seq
  import ps2seq_pkg::*;
#(
  parameter int POS_W      = 7,
  parameter int SPEC_AW    = 4,
  parameter int RING_DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             key_valid,
  input  logic [POS_W-1:0] key_pos,
  input  logic             key_make,
  input  logic             ctrl_held,
  input  logic             tbl_we,
  input  logic             tbl_sel,
  input  logic [POS_W-1:0] tbl_addr,
  input  logic [9:0]       tbl_wdata,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_byte,
  output logic             ovf
);
  localparam int SPEC_W = 10;

  logic              busy, we_map, we_spec;
  logic [7:0]        inter_a, inter_b;
  logic [SPEC_W-1:0] spec_b;
  logic              vld_a, make_a, ctrl_a;
  logic              vld_b, make_b, ctrl_b;
  seq_t              seq;
  logic [LEN_W-1:0]  len;

  assign busy    = key_valid || vld_a || vld_b;
  assign we_map  = tbl_we && !busy && !tbl_sel;
  assign we_spec = tbl_we && !busy && tbl_sel;

  ps2seq_tbl #(.W(8), .AW(POS_W)) u_map (
    .clk(clk), .we(we_map), .waddr(tbl_addr), .wdata(tbl_wdata[7:0]),
    .raddr(key_pos), .rdata(inter_a)
  );

  ps2seq_tbl #(.W(SPEC_W), .AW(SPEC_AW)) u_spec (
    .clk(clk), .we(we_spec), .waddr(tbl_addr[SPEC_AW-1:0]), .wdata(tbl_wdata),
    .raddr(inter_a[SPEC_AW-1:0]), .rdata(spec_b)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_a <= 1'b0;
      vld_b <= 1'b0;
    end else begin
      vld_a <= key_valid;
      vld_b <= vld_a;
    end
    make_a  <= key_make;
    ctrl_a  <= ctrl_held;
    make_b  <= make_a;
    ctrl_b  <= ctrl_a;
    inter_b <= inter_a;
  end

  ps2seq_build #(.SPEC_W(SPEC_W)) u_build (
    .inter(inter_b), .spec(spec_b), .make(make_b), .ctrl(ctrl_b),
    .seq(seq), .len(len)
  );

  ps2seq_ring #(.DEPTH(RING_DEPTH)) u_ring (
    .clk(clk), .rst(rst), .push(vld_b), .in_seq(seq), .in_len(len),
    .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte), .ovf(ovf)
  );
endmodule

// File: rtl/ps2seq_chk.sv
module ps2seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       key_valid,
  input logic       vld_a,
  input logic       stage_vld,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_byte,
  input logic       ovf
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && !ovf));

  a_r7_hold_byte: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));

  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);

  a_r10_first_stage: assert property (@(posedge clk) disable iff (rst)
    key_valid |=> vld_a);

  a_r10_rise_after_event: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(stage_vld));
endmodule

bind ps2_set2_seq ps2seq_chk u_chk (
  .clk(clk), .rst(rst), .key_valid(key_valid), .vld_a(vld_a),
  .stage_vld(vld_b), .out_valid(out_valid), .out_ready(out_ready),
  .out_byte(out_byte), .ovf(ovf)
);

// File: tb/sim_ps2_set2_seq.sv
`timescale 1ns/1ps
module sim_ps2_set2_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic key_valid = 1'b0, key_make = 1'b0, ctrl_held = 1'b0;
  logic [6:0] key_pos = '0;
  logic tbl_we = 1'b0, tbl_sel = 1'b0;
  logic [6:0] tbl_addr = '0;
  logic [9:0] tbl_wdata = '0;
  logic out_valid, out_ready = 1'b0, ovf;
  logic [7:0] out_byte;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] got [0:31];
  int ngot;
  logic [7:0] exp_b [0:31];
  int exp_n;

  always #2 clk = ~clk;

  ps2_set2_seq u0 (
    .clk(clk), .rst(rst), .key_valid(key_valid), .key_pos(key_pos),
    .key_make(key_make), .ctrl_held(ctrl_held), .tbl_we(tbl_we),
    .tbl_sel(tbl_sel), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte), .ovf(ovf)
  );

  function automatic logic [7:0] map_of(int p);
    if (p < 96) return 8'((p * 5 + 3) & 127);
    return 8'(8'h80 | (p & 15));
  endfunction

  function automatic logic [9:0] spec_of(int i);
    if (i < 10)  return {2'd1, 8'(8'h60 + i)};
    if (i < 12)  return {2'd2, 8'h00};
    if (i < 14)  return {2'd0, 8'h5A};
    return {2'd3, 8'h11};
  endfunction

  task automatic push_exp(logic [7:0] b);
    exp_b[exp_n] = b;
    exp_n++;
  endtask

  task automatic add_exp(int p, bit mk, bit c, logic [7:0] m);
    logic [9:0] s;
    if (!m[7]) begin
      if (!mk) push_exp(8'hF0);
      push_exp(m);
    end else begin
      s = spec_of(int'(m[3:0]));
      if (s[9:8] == 2'd1) begin
        push_exp(8'hE0);
        if (!mk) push_exp(8'hF0);
        push_exp(s[7:0]);
      end else if (s[9:8] == 2'd2 && mk) begin
        if (c) begin
          push_exp(8'hE0); push_exp(8'h7E); push_exp(8'hE0);
          push_exp(8'hF0); push_exp(8'h7E);
        end else begin
          push_exp(8'hE1); push_exp(8'h14); push_exp(8'h77); push_exp(8'hE1);
          push_exp(8'hF0); push_exp(8'h14); push_exp(8'hF0); push_exp(8'h77);
        end
      end
    end
  endtask

  task automatic check(bit ok, string req, string what, int act, int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic check_seq(string req, int p);
    bit ok = (ngot == exp_n);
    int first_bad = -1;
    for (int i = 0; i < exp_n && i < ngot; i++)
      if (got[i] !== exp_b[i] && first_bad < 0) first_bad = i;
    if (first_bad >= 0) ok = 0;
    n_run++;
    if (!ok) begin
      n_fail++;
      if (first_bad >= 0)
        $display("FAIL %s pos %0d byte %0d: actual %0h expected %0h",
                 req, p, first_bad, got[first_bad], exp_b[first_bad]);
      else
        $display("FAIL %s pos %0d length: actual %0d expected %0d", req, p, ngot, exp_n);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr_tbl(bit sel, int addr, logic [9:0] d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_sel = sel; tbl_addr = 7'(addr); tbl_wdata = d;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic send(int p, bit mk, bit c);
    @(negedge clk);
    key_valid = 1'b1; key_pos = 7'(p); key_make = mk; ctrl_held = c;
    @(negedge clk);
    key_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic drain(bit alt);
    int idle = 0;
    bit r = 1'b0;
    ngot = 0;
    while (idle < 4 && ngot < 32) begin
      @(negedge clk);
      r = alt ? !r : 1'b1;
      out_ready = r;
      if (out_valid) begin
        idle = 0;
        if (r) begin got[ngot] = out_byte; ngot++; end
      end else idle++;
    end
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    #600000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: reset state
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(ovf == 1'b0, "R1", "ovf after reset", ovf, 0);

    // R2 / R4: load both tables
    for (int p = 0; p < 128; p++) wr_tbl(1'b0, p, {2'b00, map_of(p)});
    for (int i = 0; i < 16; i++) wr_tbl(1'b1, i, spec_of(i));

    // R3 R4 R5 R6: sweep every position, press and release, Ctrl both ways
    for (int p = 0; p < 128; p++) begin
      for (int mk = 0; mk < 2; mk++) begin
        for (int c = 0; c < 2; c++) begin
          send(p, mk[0], c[0]);
          drain(1'b0);
          exp_n = 0;
          add_exp(p, mk[0], c[0], map_of(p));
          check_seq(p < 96 ? "R3" : "R4_R5_R6", p);
        end
      end
    end

    // R10: latency with empty buffer
    @(negedge clk);
    key_valid = 1'b1; key_pos = 7'd3; key_make = 1'b1; ctrl_held = 1'b0;
    @(negedge clk); key_valid = 1'b0;
    check(out_valid == 1'b0, "R10", "valid after edge 1", out_valid, 0);
    @(negedge clk);
    check(out_valid == 1'b0, "R10", "valid after edge 2", out_valid, 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R10", "valid after edge 3", out_valid, 1);
    check(out_byte == map_of(3), "R10", "first byte", out_byte, map_of(3));
    drain(1'b0);

    // R7: hold while not ready, then ordered drain with gapped ready
    exp_n = 0;
    send(96, 1'b0, 1'b0); add_exp(96, 1'b0, 1'b0, map_of(96));
    send(20, 1'b0, 1'b0); add_exp(20, 1'b0, 1'b0, map_of(20));
    repeat (5) @(negedge clk);
    check(out_valid && out_byte == 8'hE0, "R7", "held first byte", out_byte, 8'hE0);
    drain(1'b1);
    check_seq("R7", 20);

    // R8: fill completely, then one more is dropped
    do_reset();
    exp_n = 0;
    for (int p = 0; p < 16; p++) begin send(p, 1'b1, 1'b0); push_exp(map_of(p)); end
    check(ovf == 1'b0, "R8", "ovf when exactly full", ovf, 0);
    send(16, 1'b1, 1'b0);
    check(ovf == 1'b1, "R8", "ovf after drop", ovf, 1);
    drain(1'b0);
    check_seq("R8", 16);
    check(ovf == 1'b1, "R8", "ovf sticky after drain", ovf, 1);

    // R8: partial fill rejects Pause, admits extended release
    do_reset();
    exp_n = 0;
    for (int p = 0; p < 5; p++) begin send(p, 1'b0, 1'b0); add_exp(p, 1'b0, 1'b0, map_of(p)); end
    send(106, 1'b1, 1'b0);
    check(ovf == 1'b1, "R8", "ovf on Pause not fitting", ovf, 1);
    send(96, 1'b0, 1'b0); add_exp(96, 1'b0, 1'b0, map_of(96));
    drain(1'b0);
    check_seq("R8", 96);

    // R6: Pause release gives no bytes and no overflow
    do_reset();
    send(106, 1'b0, 1'b0);
    send(107, 1'b0, 1'b1);
    check(out_valid == 1'b0, "R6", "Pause release bytes", out_valid, 0);
    check(ovf == 1'b0, "R6", "Pause release ovf", ovf, 0);

    // R9: write in same cycle as event is ignored
    @(negedge clk);
    key_valid = 1'b1; key_pos = 7'd5; key_make = 1'b1;
    tbl_we = 1'b1; tbl_sel = 1'b0; tbl_addr = 7'd5; tbl_wdata = 10'h033;
    @(negedge clk); key_valid = 1'b0; tbl_we = 1'b0;
    repeat (3) @(negedge clk);
    drain(1'b0);
    check(ngot == 1 && got[0] == map_of(5), "R9", "same-cycle event code", got[0], map_of(5));
    // R9: write one cycle after event is ignored
    @(negedge clk);
    key_valid = 1'b1; key_pos = 7'd7; key_make = 1'b1;
    @(negedge clk); key_valid = 1'b0;
    tbl_we = 1'b1; tbl_sel = 1'b0; tbl_addr = 7'd5; tbl_wdata = 10'h044;
    @(negedge clk); tbl_we = 1'b0;
    repeat (3) @(negedge clk);
    drain(1'b0);
    send(5, 1'b1, 1'b0);
    drain(1'b0);
    check(ngot == 1 && got[0] == map_of(5), "R9", "table kept after blocked writes", got[0], map_of(5));

    // R2: idle write reloads the layout
    wr_tbl(1'b0, 5, 10'h033);
    send(5, 1'b1, 1'b0);
    drain(1'b0);
    check(ngot == 1 && got[0] == 8'h33, "R2", "reloaded entry", got[0], 8'h33);
    wr_tbl(1'b1, 0, {2'd1, 8'h4A});
    send(96, 1'b1, 1'b0);
    drain(1'b0);
    check(ngot == 2 && got[1] == 8'h4A, "R4", "reloaded second table", got[1], 8'h4A);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule